// File: doc/BRIEF.md
# Colour Lookup Table Write Sequencer

This block fills a 256-entry colour lookup table from a 32-bit write bus and serves a display pipeline that turns 8-bit pixel indices into 24-bit colours. Three byte lanes of the bus each reach their own register. One lane loads the entry pointer. One lane takes colour components, one byte per write. One lane loads a pixel mask register. A single write acts on only one lane, picked by a fixed priority over the byte enables.

Colour components arrive as a run of single-byte writes: red, then green, then blue. A three-step stage counter holds red and green until blue arrives. The blue write then stores all three components at the pointed entry in one table write. After that the pointer moves to the next entry, wrapping from 255 to 0, so a whole table can be loaded as one long stream of component writes after a single pointer write. The lookup side is a registered read with block RAM timing.

Top module: `clut_write_sequencer`

## Requirements
- R1: After reset the pointer is 0, the stage is red, held components are 0, `mask_q` is 0 and `lk_color` is 0; component writes with no prior pointer write fill entry 0 first.
- R2: A write on the pointer lane (enable `wr_be[0]`, data `wr_data[7:0]`) loads the pointer, returns the stage to red and discards any red or green already held.
- R3: Writes on the component lane (enable `wr_be[1]`, data `wr_data[15:8]`) are taken as red, then green, then blue, one stage per write.
- R4: The blue write stores the entry as red in bits 23:16, green in 15:8 and blue in 7:0, at the current pointer, in the same clock edge.
- R5: After each stored entry the pointer increments modulo 256 and the stage returns to red.
- R6: A write on the mask lane (enable `wr_be[2]`, data `wr_data[23:16]`) loads `mask_q` and changes neither the lookup result, the pointer nor the stage.
- R7: Lane priority is pointer over component over mask; only the highest enabled lane acts. `wr_be[3]` and any write with `wr_en` low have no effect.
- R8: `lk_color` shows the entry addressed by `lk_idx` one clock after the index is sampled.
- R9: When a lookup and a stored entry hit the same index on the same edge, the lookup returns the value held before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data, one byte per lane |
| lk_idx | input | 8 | Pixel index for lookup |
| lk_color | output | 24 | Registered colour of the indexed entry |
| mask_q | output | 8 | Pixel mask register |

## Verification
The bench builds the block with its default parameters: 8-bit index, 8-bit components and a 32-bit bus with the pointer, component and mask lanes at bytes 0, 1 and 2. With only 256 entries, a single stream of 768 component writes reaches every entry and the pointer wrap. Random enables on all four lanes cover every priority combination and the unused top lane. Random lookup indices often hit the entry being stored, so the read-before-write case comes up in the random phase as well as in a directed case.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    ST_RED = 2'd0,
    ST_GRN = 2'd1,
    ST_BLU = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PTR  = 2'd1,
    OP_COMP = 2'd2,
    OP_MASK = 2'd3
  } op_e;
endpackage

// File: rtl/clut_lane_decode.sv
module clut_lane_decode
  import clut_pkg::*;
#(
  parameter int BUS_W     = 32,
  parameter int LANE_W    = 8,
  parameter int PTR_LANE  = 0,
  parameter int COMP_LANE = 1,
  parameter int MASK_LANE = 2
) (
  input  logic                      wr_en,
  input  logic [BUS_W/LANE_W-1:0]   wr_be,
  input  logic [BUS_W-1:0]          wr_data,
  output op_e                       op,
  output logic [LANE_W-1:0]         lane_byte
);
  localparam int LANES = BUS_W / LANE_W;
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANE_W-1:0] lanes [LANES];
  logic [SEL_W-1:0]  sel;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = wr_data[g*LANE_W +: LANE_W];
  end

  // fixed priority: pointer, then component, then mask
  always_comb begin
    op  = OP_NONE;
    sel = SEL_W'(PTR_LANE);
    if (wr_en) begin
      if (wr_be[PTR_LANE]) begin
        op  = OP_PTR;
        sel = SEL_W'(PTR_LANE);
      end else if (wr_be[COMP_LANE]) begin
        op  = OP_COMP;
        sel = SEL_W'(COMP_LANE);
      end else if (wr_be[MASK_LANE]) begin
        op  = OP_MASK;
        sel = SEL_W'(MASK_LANE);
      end
    end
  end

  assign lane_byte = lanes[sel];
endmodule

// File: rtl/clut_stage_collector.sv
module clut_stage_collector
  import clut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  op_e                 op,
  input  logic [COMP_W-1:0]   lane_byte,
  output logic                commit_we,
  output logic [IDX_W-1:0]    commit_idx,
  output logic [3*COMP_W-1:0] commit_rgb
);
  stage_e            stage_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [COMP_W-1:0] red_q, grn_q;

  assign commit_we  = (op == OP_COMP) && (stage_q == ST_BLU);
  assign commit_idx = ptr_q;
  assign commit_rgb = {red_q, grn_q, lane_byte};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_RED;
      ptr_q   <= '0;
      red_q   <= '0;
      grn_q   <= '0;
    end else begin
      unique case (op)
        OP_PTR: begin
          ptr_q   <= lane_byte[IDX_W-1:0];
          stage_q <= ST_RED;
          red_q   <= '0;
          grn_q   <= '0;
        end
        OP_COMP: begin
          unique case (stage_q)
            ST_RED: begin
              red_q   <= lane_byte;
              stage_q <= ST_GRN;
            end
            ST_GRN: begin
              grn_q   <= lane_byte;
              stage_q <= ST_BLU;
            end
            default: begin
              ptr_q   <= ptr_q + 1'b1;
              stage_q <= ST_RED;
              red_q   <= '0;
              grn_q   <= '0;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    stage_q != 2'd3) else $error("stage out of range"); // R3
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_PTR) |=> (stage_q == ST_RED && red_q == '0 && grn_q == '0
                        && ptr_q == $past(lane_byte[IDX_W-1:0]))) else $error("pointer load"); // R2
  AST_COMP_STEP: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COMP && stage_q == ST_RED) |=> (stage_q == ST_GRN)) else $error("stage step"); // R3
  AST_COMMIT_ADV: assert property (@(posedge clk) disable iff (rst)
    commit_we |=> (ptr_q == $past(ptr_q) + 1'b1 && stage_q == ST_RED)) else $error("advance"); // R5
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MASK) |=> ($stable(ptr_q) && $stable(stage_q))) else $error("mask side effect"); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NONE) |=> ($stable(ptr_q) && $stable(stage_q) && $stable(red_q))) else $error("idle"); // R7
endmodule

// File: rtl/clut_table.sv
module clut_table #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // registered read, old data on a same-edge write
  always_ff @(posedge clk) begin
    if (rst) rd <= '0;
    else     rd <= mem[ra];
  end

  AST_RD_AFTER_RST: assert property (@(posedge clk)
    $fell(rst) |-> (rd == '0)) else $error("read reg not cleared"); // R1
endmodule

// File: rtl/clut_write_sequencer.sv
module clut_write_sequencer
  import clut_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int COMP_W    = 8,
  parameter int BUS_W     = 32,
  parameter int PTR_LANE  = 0,
  parameter int COMP_LANE = 1,
  parameter int MASK_LANE = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [BUS_W/COMP_W-1:0]   wr_be,
  input  logic [BUS_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]          lk_idx,
  output logic [3*COMP_W-1:0]       lk_color,
  output logic [COMP_W-1:0]         mask_q
);
  localparam int RGB_W = 3 * COMP_W;

  op_e               op;
  logic [COMP_W-1:0] lane_byte;
  logic              commit_we;
  logic [IDX_W-1:0]  commit_idx;
  logic [RGB_W-1:0]  commit_rgb;

  clut_lane_decode #(
    .BUS_W(BUS_W), .LANE_W(COMP_W),
    .PTR_LANE(PTR_LANE), .COMP_LANE(COMP_LANE), .MASK_LANE(MASK_LANE)
  ) dec_i (
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .op(op), .lane_byte(lane_byte)
  );

  clut_stage_collector #(.IDX_W(IDX_W), .COMP_W(COMP_W)) col_i (
    .clk(clk), .rst(rst), .op(op), .lane_byte(lane_byte),
    .commit_we(commit_we), .commit_idx(commit_idx), .commit_rgb(commit_rgb)
  );

  clut_table #(.IDX_W(IDX_W), .DATA_W(RGB_W)) tab_i (
    .clk(clk), .rst(rst), .we(commit_we), .wa(commit_idx), .wd(commit_rgb),
    .ra(lk_idx), .rd(lk_color)
  );

  always_ff @(posedge clk) begin
    if (rst)                mask_q <= '0;
    else if (op == OP_MASK) mask_q <= lane_byte;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MASK) |=> (mask_q == $past(wr_data[MASK_LANE*COMP_W +: COMP_W]))) else $error("mask load"); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (op != OP_MASK) |=> $stable(mask_q)) else $error("mask changed"); // R7
  AST_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_be[PTR_LANE]) |-> (op == OP_PTR && !commit_we)) else $error("priority"); // R7
endmodule

// File: tb/clut_write_sequencer_tb.sv
`timescale 1ns/1ps
module clut_write_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_color;
  logic [7:0]  mask_q;

  always #2 clk = ~clk;

  clut_write_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .lk_idx(lk_idx), .lk_color(lk_color), .mask_q(mask_q)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [23:0] m_tab [256];
  bit          m_known [256];
  int          m_ptr, m_stg;
  logic [7:0]  m_red, m_grn, m_mask;

  function automatic logic [23:0] fill_val(input int i);
    return {8'(i * 7 + 3), 8'(i ^ 8'hA5), 8'(255 - i)};
  endfunction

  function automatic logic [31:0] comp_word(input logic [7:0] b);
    return {8'hEE, 8'h00, b, 8'h00};
  endfunction

  task automatic check24(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %06h expected %06h", tag, act, exp);
    end
  endtask

  task automatic model_apply(input bit we, input logic [3:0] be, input logic [31:0] d);
    if (!we) return;
    if (be[0]) begin
      m_ptr = d[7:0]; m_stg = 0; m_red = 0; m_grn = 0;
    end else if (be[1]) begin
      case (m_stg)
        0: begin m_red = d[15:8]; m_stg = 1; end
        1: begin m_grn = d[15:8]; m_stg = 2; end
        default: begin
          m_tab[m_ptr]   = {m_red, m_grn, d[15:8]};
          m_known[m_ptr] = 1;
          m_ptr = (m_ptr + 1) % 256;
          m_stg = 0; m_red = 0; m_grn = 0;
        end
      endcase
    end else if (be[2]) begin
      m_mask = d[23:16];
    end
  endtask

  // one clock: drive write and lookup, check lookup (old table) and mask
  task automatic step(input bit we, input logic [3:0] be, input logic [31:0] d,
                      input logic [7:0] idx, input string tag);
    logic [23:0] old_v;
    bit          old_k;
    @(negedge clk);
    wr_en = we; wr_be = be; wr_data = d; lk_idx = idx;
    @(posedge clk);
    old_v = m_tab[idx];
    old_k = m_known[idx];
    model_apply(we, be, d);
    #1;
    if (old_k) check24(tag, lk_color, old_v);
    check24({tag, " mask"}, {16'h0, mask_q}, {16'h0, m_mask});
  endtask

  task automatic comp(input logic [7:0] b, input string tag);
    step(1, 4'b0010, comp_word(b), 8'h00, tag);
  endtask

  task automatic look(input logic [7:0] idx, input string tag);
    step(0, 4'b0000, 32'h0, idx, tag);
    step(0, 4'b0000, 32'h0, idx, tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin m_tab[i] = '0; m_known[i] = 0; end
    m_ptr = 0; m_stg = 0; m_red = 0; m_grn = 0; m_mask = 0;
    void'($urandom(32'h5EED_C10F));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check24("R1 lookup reset", lk_color, 24'h0);
    check24("R1 mask reset", {16'h0, mask_q}, 24'h0);

    // R1: pointer starts at entry 0
    comp(8'h11, "R1"); comp(8'h22, "R1"); comp(8'h33, "R1");
    look(8'h00, "R1 entry0");
    check24("R1 entry0 direct", lk_color, 24'h112233);

    // R3 R4: full table fill after one pointer write
    step(1, 4'b0001, 32'h0, 8'h00, "R2");
    for (int i = 0; i < 256; i++) begin
      logic [23:0] v = fill_val(i);
      comp(v[23:16], "R3"); comp(v[15:8], "R3"); comp(v[7:0], "R4");
    end
    for (int i = 0; i < 256; i += 37) look(8'(i), "R4 fill");
    look(8'hFF, "R4 last");

    // R5: pointer wrapped to 0
    comp(8'hA1, "R5"); comp(8'hA2, "R5"); comp(8'hA3, "R5");
    look(8'h00, "R5 wrap");
    check24("R5 wrap direct", lk_color, 24'hA1A2A3);
    look(8'h01, "R5 next untouched");

    // R2: pointer write drops partial components
    step(1, 4'b0001, 32'h0000_000A, 8'h0, "R2");
    comp(8'h01, "R2"); comp(8'h02, "R2");
    step(1, 4'b0001, 32'h0000_0014, 8'h0, "R2");
    comp(8'hC1, "R2"); comp(8'hC2, "R2"); comp(8'hC3, "R2");
    look(8'h14, "R2 new entry");
    check24("R2 new entry direct", lk_color, 24'hC1C2C3);
    look(8'h0A, "R2 old entry kept");

    // R6: mask write mid-sequence
    step(1, 4'b0001, 32'h0000_001E, 8'h0, "R6");
    comp(8'h51, "R6");
    step(1, 4'b0100, 32'h005A_0000, 8'h1E, "R6");
    check24("R6 mask loaded", {16'h0, mask_q}, 24'h00005A);
    comp(8'h52, "R6"); comp(8'h53, "R6");
    look(8'h1E, "R6 entry");
    check24("R6 entry direct", lk_color, 24'h515253);

    // R7: priority and ignored writes
    step(1, 4'b0111, 32'h0055_AA40, 8'h0, "R7");
    step(1, 4'b0110, 32'h0077_6100, 8'h0, "R7");
    step(1, 4'b0110, 32'h0077_6200, 8'h0, "R7");
    step(1, 4'b0110, 32'h0077_6300, 8'h0, "R7");
    step(1, 4'b1000, 32'hFFFF_FFFF, 8'h0, "R7");
    step(0, 4'b1111, 32'h0000_7700, 8'h0, "R7");
    comp(8'h71, "R7"); comp(8'h72, "R7"); comp(8'h73, "R7");
    look(8'h40, "R7 data over mask");
    check24("R7 direct 40", lk_color, 24'h616263);
    look(8'h41, "R7 ignored writes");
    check24("R7 direct 41", lk_color, 24'h717273);

    // R9: lookup on the entry being stored
    step(1, 4'b0001, 32'h0000_0032, 8'h0, "R9");
    comp(8'hD1, "R9"); comp(8'hD2, "R9");
    step(1, 4'b0010, comp_word(8'hD3), 8'h32, "R9 same edge");
    step(0, 4'b0000, 32'h0, 8'h32, "R9 after");
    check24("R9 after direct", lk_color, 24'hD1D2D3);

    // R8: random mix
    for (int i = 0; i < 4000; i++) begin
      bit          we  = ($urandom % 8) != 0;
      logic [3:0]  be  = 4'($urandom);
      logic [31:0] d   = $urandom;
      logic [7:0]  idx = ((i % 5) == 0) ? 8'(m_ptr) : 8'($urandom);
      if (($urandom % 4) != 0 && be[0]) be[0] = 1'b0;
      step(we, be, d, idx, "R8 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule